// File: doc/BRIEF.md
# Revertive Reference Clock Selector

This block is the control state machine in front of a clock-cleaning PLL. It decides which reference feeds the PLL: input A, input B or a fallback input F. When none of them can be used, it puts the PLL into holdover. Alarm detectors outside the block report two conditions per input: loss of signal and frequency offset. A separate pin says whether the fallback input is fitted at all. The block only reads these flags. It does not measure the clocks.

In automatic mode the block picks a reference from the alarm state. The priority is fixed, with A first, B second, F third and holdover last. A revertive pin sets the policy. With the pin high, the block always moves back to the best clean input. With the pin low, it stays on the current input for as long as that input is clean. A mask pin lets frequency-offset alarms be ignored, so that only loss of signal can force a switch. In manual mode a select code chooses the reference directly. The selection is registered. A one-cycle strobe marks every change of selection, so the phase logic downstream can capture the offset at that moment.

Top module: `refsel_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, the selection is input A (code 0), the holdover flag is low and the strobe is low.
- R2: With the auto input low, the next selection is the manual code: 0 is A, 1 is B, 2 is F, and any code of 3 or more means holdover (code 3). Alarms are ignored in manual mode.
- R3: In automatic mode, an input is unusable when its loss-of-signal flag or its frequency-offset flag is set. When the selected input becomes unusable, the selection moves to the highest-priority usable input.
- R4: The priority is A, then B, then F, then holdover. F is usable only while its present pin is high, so with A and B alarmed the block selects F if F is present and clean, and otherwise selects holdover.
- R5: In revertive automatic mode, the selection is always the highest-priority usable input. The block returns to a higher-priority input on the cycle after that input's alarms clear.
- R6: In non-revertive automatic mode, a usable current selection is kept, even when a higher-priority input becomes usable.
- R7: Holdover is left for the highest-priority usable input as soon as any input becomes usable. This applies in both policies.
- R8: While the mask pin is high in automatic mode, frequency-offset flags do not count when judging whether an input is usable.
- R9: The selection appears one clock after the inputs that cause it. The one-hot output matches the code, and it is all zero exactly when the holdover flag is high.
- R10: The strobe is high for exactly those cycles in which the selection code differs from its value one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Control clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| auto_en_i | input | 1 | 1 = automatic selection, 0 = manual code |
| revert_en_i | input | 1 | 1 = revertive policy, 0 = non-revertive |
| foa_mask_i | input | 1 | 1 = ignore frequency-offset alarms |
| man_sel_i | input | SEL_W (2) | Manual selection code |
| los_i | input | NUM_REF (3) | Loss-of-signal flags, bit 0 = A, bit 1 = B, bit 2 = F |
| foa_i | input | NUM_REF (3) | Frequency-offset flags, same bit order |
| fallback_present_i | input | 1 | Lowest-priority input is fitted |
| sel_onehot_o | output | NUM_REF (3) | One-hot selection, zero in holdover |
| sel_code_o | output | SEL_W (2) | Selection code, NUM_REF = holdover |
| holdover_o | output | 1 | Holdover active |
| switch_o | output | 1 | One-cycle strobe on a change of selection |

## Verification
The bench uses the default of three references, which gives a 2-bit code. The control and alarm inputs then form a 12-bit vector of 4096 patterns. The bench applies every pattern in two scrambled orders, so each pattern is met from several current selections. It then runs long random stretches with the mode held fixed, which reaches the revertive and non-revertive paths into and out of holdover. A bench model checks every cycle's code, one-hot output, holdover flag and strobe.

// File: rtl/refsel_pkg.sv
package refsel_pkg;

  // Decision policy applied by the next-state logic
  typedef enum logic [1:0] {
    POL_MANUAL = 2'd0,
    POL_REVERT = 2'd1,
    POL_HOLDON = 2'd2
  } policy_e;

endpackage

// File: rtl/refsel_qualify.sv
// Turns raw alarm flags into a per-input usable vector.
module refsel_qualify #(
  parameter int NUM_REF = 3
) (
  input  logic [NUM_REF-1:0] los_i,
  input  logic [NUM_REF-1:0] foa_i,
  input  logic               foa_mask_i,
  input  logic               fallback_present_i,
  output logic [NUM_REF-1:0] usable_o
);

  localparam int LAST = NUM_REF - 1;

  for (genvar g = 0; g < NUM_REF; g++) begin : g_ref
    logic foa_eff;
    assign foa_eff = foa_i[g] & ~foa_mask_i;
    if (g == LAST) begin : g_fallback
      assign usable_o[g] = ~los_i[g] & ~foa_eff & fallback_present_i;
    end else begin : g_main
      assign usable_o[g] = ~los_i[g] & ~foa_eff;
    end
  end

endmodule

// File: rtl/refsel_prio.sv
// Fixed priority encoder: lowest index wins, none usable -> holdover code.
module refsel_prio #(
  parameter int NUM_REF = 3,
  parameter int SEL_W   = $clog2(NUM_REF + 1)
) (
  input  logic [NUM_REF-1:0] usable_i,
  output logic [SEL_W-1:0]   best_o
);

  localparam logic [SEL_W-1:0] HOLD_CODE = SEL_W'(NUM_REF);

  always_comb begin
    best_o = HOLD_CODE;
    for (int i = NUM_REF - 1; i >= 0; i--) begin
      if (usable_i[i]) best_o = SEL_W'(i);
    end
  end

endmodule

// File: rtl/refsel_policy.sv
// Next-state decision for the selection register.
module refsel_policy
  import refsel_pkg::*;
#(
  parameter int NUM_REF = 3,
  parameter int SEL_W   = $clog2(NUM_REF + 1)
) (
  input  policy_e            policy_i,
  input  logic [SEL_W-1:0]   cur_i,
  input  logic [NUM_REF-1:0] usable_i,
  input  logic [SEL_W-1:0]   best_i,
  input  logic [SEL_W-1:0]   man_sel_i,
  output logic [SEL_W-1:0]   next_o
);

  localparam logic [SEL_W-1:0] HOLD_CODE = SEL_W'(NUM_REF);

  logic             cur_ok;
  logic [SEL_W-1:0] man_code;

  // Is the present selection still a usable reference?
  always_comb begin
    cur_ok = 1'b0;
    for (int i = 0; i < NUM_REF; i++) begin
      if (cur_i == SEL_W'(i)) cur_ok = usable_i[i];
    end
  end

  // Out-of-range manual codes fold onto holdover
  assign man_code = (man_sel_i >= HOLD_CODE) ? HOLD_CODE : man_sel_i;

  always_comb begin
    unique case (policy_i)
      POL_MANUAL: next_o = man_code;
      POL_REVERT: next_o = best_i;
      POL_HOLDON: next_o = cur_ok ? cur_i : best_i;
      default:    next_o = best_i;
    endcase
  end

endmodule

// File: rtl/refsel_ctrl.sv
// Reference clock selector: priority chain A > B > F > holdover.
module refsel_ctrl
  import refsel_pkg::*;
#(
  parameter int NUM_REF = 3,
  parameter int SEL_W   = $clog2(NUM_REF + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               auto_en_i,
  input  logic               revert_en_i,
  input  logic               foa_mask_i,
  input  logic [SEL_W-1:0]   man_sel_i,
  input  logic [NUM_REF-1:0] los_i,
  input  logic [NUM_REF-1:0] foa_i,
  input  logic               fallback_present_i,
  output logic [NUM_REF-1:0] sel_onehot_o,
  output logic [SEL_W-1:0]   sel_code_o,
  output logic               holdover_o,
  output logic               switch_o
);

  localparam logic [SEL_W-1:0] HOLD_CODE = SEL_W'(NUM_REF);

  policy_e            policy;
  logic [NUM_REF-1:0] usable;
  logic [SEL_W-1:0]   best;
  logic [SEL_W-1:0]   sel_d, sel_q;
  logic               sel_en;
  logic               sw_q;

  always_comb begin
    if (!auto_en_i)       policy = POL_MANUAL;
    else if (revert_en_i) policy = POL_REVERT;
    else                  policy = POL_HOLDON;
  end

  refsel_qualify #(.NUM_REF(NUM_REF)) u_qualify (
    .los_i              (los_i),
    .foa_i              (foa_i),
    .foa_mask_i         (foa_mask_i),
    .fallback_present_i (fallback_present_i),
    .usable_o           (usable)
  );

  refsel_prio #(.NUM_REF(NUM_REF), .SEL_W(SEL_W)) u_prio (
    .usable_i (usable),
    .best_o   (best)
  );

  refsel_policy #(.NUM_REF(NUM_REF), .SEL_W(SEL_W)) u_policy (
    .policy_i  (policy),
    .cur_i     (sel_q),
    .usable_i  (usable),
    .best_i    (best),
    .man_sel_i (man_sel_i),
    .next_o    (sel_d)
  );

  assign sel_en = (sel_d != sel_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= '0;
    end else if (sel_en) begin
      sel_q <= sel_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sw_q <= 1'b0;
    else         sw_q <= sel_en;
  end

  for (genvar g = 0; g < NUM_REF; g++) begin : g_dec
    assign sel_onehot_o[g] = (sel_q == SEL_W'(g));
  end

  assign sel_code_o = sel_q;
  assign holdover_o = (sel_q == HOLD_CODE);
  assign switch_o   = sw_q;

endmodule

// File: rtl/refsel_ctrl_chk.sv
module refsel_ctrl_chk #(
  parameter int NUM_REF = 3,
  parameter int SEL_W   = $clog2(NUM_REF + 1)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               auto_en_i,
  input logic               revert_en_i,
  input logic               foa_mask_i,
  input logic [SEL_W-1:0]   man_sel_i,
  input logic [NUM_REF-1:0] los_i,
  input logic [NUM_REF-1:0] foa_i,
  input logic               fallback_present_i,
  input logic [NUM_REF-1:0] sel_onehot_o,
  input logic [SEL_W-1:0]   sel_code_o,
  input logic               holdover_o,
  input logic               switch_o
);

  logic [SEL_W-1:0] man_exp;
  logic             cur_clean;

  assign man_exp = (man_sel_i >= SEL_W'(NUM_REF)) ? SEL_W'(NUM_REF) : man_sel_i;

  always_comb begin
    cur_clean = 1'b0;
    for (int i = 0; i < NUM_REF; i++) begin
      if (sel_code_o == SEL_W'(i))
        cur_clean = !los_i[i] && (!foa_i[i] || foa_mask_i) &&
                    ((i != NUM_REF - 1) || fallback_present_i);
    end
  end

  p_onehot_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel_onehot_o) && (holdover_o == (sel_onehot_o == '0)));

  p_strobe_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    switch_o == (sel_code_o != $past(sel_code_o)));

  p_manual_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !auto_en_i |=> sel_code_o == $past(man_exp));

  p_top_clean_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auto_en_i && revert_en_i && !los_i[0] && (!foa_i[0] || foa_mask_i))
    |=> sel_code_o == '0);

  p_all_lost_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auto_en_i && (&los_i)) |=> holdover_o);

  p_keep_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auto_en_i && !revert_en_i && !holdover_o && cur_clean)
    |=> $stable(sel_code_o));

  p_mask_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auto_en_i && foa_mask_i && (los_i[1:0] == '0)) |=> !holdover_o);

endmodule

bind refsel_ctrl refsel_ctrl_chk #(.NUM_REF(NUM_REF), .SEL_W(SEL_W)) u_chk (
  .clk_i              (clk_i),
  .rst_ni             (rst_ni),
  .auto_en_i          (auto_en_i),
  .revert_en_i        (revert_en_i),
  .foa_mask_i         (foa_mask_i),
  .man_sel_i          (man_sel_i),
  .los_i              (los_i),
  .foa_i              (foa_i),
  .fallback_present_i (fallback_present_i),
  .sel_onehot_o       (sel_onehot_o),
  .sel_code_o         (sel_code_o),
  .holdover_o         (holdover_o),
  .switch_o           (switch_o)
);

// File: tb/test_refsel_ctrl.sv
module test_refsel_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int NR = 3;
  localparam int SW = 2;
  localparam int HOLD = NR;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          auto_en, revert_en, foa_mask, present;
  logic [SW-1:0] man_sel;
  logic [NR-1:0] los, foa;
  logic [NR-1:0] onehot;
  logic [SW-1:0] code;
  logic          hold, sw;

  int n_tests = 0;
  int n_fail  = 0;
  int exp_sel = 0;
  bit done    = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  refsel_ctrl i_refsel_ctrl (
    .clk_i              (clk),
    .rst_ni             (rst_n),
    .auto_en_i          (auto_en),
    .revert_en_i        (revert_en),
    .foa_mask_i         (foa_mask),
    .man_sel_i          (man_sel),
    .los_i              (los),
    .foa_i              (foa),
    .fallback_present_i (present),
    .sel_onehot_o       (onehot),
    .sel_code_o         (code),
    .holdover_o         (hold),
    .switch_o           (sw)
  );

  task automatic check(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // Requirement model of the next selection
  function automatic int model(int cur, bit au, bit rv, bit mk,
                               logic [2:0] ls, logic [2:0] fo, bit pr, int ms);
    bit ok [NR];
    int best = HOLD;
    for (int i = 0; i < NR; i++)
      ok[i] = !ls[i] && !(fo[i] && !mk) && (i != NR - 1 || pr);
    for (int i = NR - 1; i >= 0; i--) if (ok[i]) best = i;
    if (!au) return (ms >= NR) ? HOLD : ms;
    if (rv) return best;
    if (cur < NR && ok[cur]) return cur;
    return best;
  endfunction

  task automatic check_outputs(string tag, int exp, bit exp_sw);
    check(tag, int'(code), exp);
    check("R9 onehot", int'(onehot), (exp == HOLD) ? 0 : (1 << exp));
    check("R9 holdover", int'(hold), (exp == HOLD) ? 1 : 0);
    check("R10 strobe", int'(sw), int'(exp_sw));
  endtask

  // Called at a falling edge; returns at the next falling edge after checking
  task automatic apply(string tag, bit au, bit rv, bit mk,
                       logic [2:0] ls, logic [2:0] fo, bit pr, int ms);
    int nxt;
    auto_en = au; revert_en = rv; foa_mask = mk;
    los = ls; foa = fo; present = pr; man_sel = SW'(ms);
    nxt = model(exp_sel, au, rv, mk, ls, fo, pr, ms);
    @(posedge clk);
    @(negedge clk);
    check_outputs(tag, nxt, nxt != exp_sel);
    exp_sel = nxt;
  endtask

  task automatic apply_vec(int v);
    string tag;
    bit au = v[11];
    bit rv = v[10];
    tag = !au ? "R2 manual" : (rv ? "R5 revertive" : "R6 nonrevertive");
    apply(tag, au, rv, v[9], v[8:6], v[5:3], v[2], v[1:0]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R1..all watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    auto_en = 1'b1; revert_en = 1'b1; foa_mask = 1'b0; present = 1'b1;
    man_sel = '0; los = '0; foa = '0;
    repeat (3) @(negedge clk);
    check("R1 reset code", int'(code), 0);
    check("R1 reset holdover", int'(hold), 0);
    check("R1 reset strobe", int'(sw), 0);
    rst_n = 1'b1;
    apply("R1 after reset", 1, 1, 0, 3'b000, 3'b000, 1, 0);

    // Directed corner cases, revertive
    apply("R3 A lost", 1, 1, 0, 3'b001, 3'b000, 1, 0);
    apply("R3 A freq alarm", 1, 1, 0, 3'b000, 3'b001, 1, 0);
    apply("R8 mask freq alarm", 1, 1, 1, 3'b000, 3'b001, 1, 0);
    apply("R4 fall to F", 1, 1, 0, 3'b011, 3'b000, 1, 0);
    apply("R4 F absent", 1, 1, 0, 3'b011, 3'b000, 0, 0);
    apply("R7 leave hold nonrev", 1, 0, 0, 3'b001, 3'b000, 0, 0);
    apply("R6 keep B", 1, 0, 0, 3'b000, 3'b000, 1, 0);
    apply("R5 revert to A", 1, 1, 0, 3'b000, 3'b000, 1, 0);
    apply("R2 manual hold", 0, 1, 0, 3'b111, 3'b111, 0, 3);
    apply("R7 leave hold rev", 1, 1, 0, 3'b010, 3'b000, 1, 0);
    apply("R2 manual F alarmed", 0, 0, 0, 3'b100, 3'b100, 0, 2);

    // Two scrambled passes over every input pattern
    for (int pass = 0; pass < 2; pass++)
      for (int k = 0; k < 4096; k++)
        apply_vec(((k * (pass == 0 ? 2731 : 1365)) + pass * 77) & 4095);

    // Random stretches with mode held fixed
    for (int blk = 0; blk < 64; blk++) begin
      bit rv = blk[0];
      bit mk = blk[1];
      for (int c = 0; c < 64; c++) begin
        logic [2:0] ls = 3'($urandom) & 3'($urandom);
        logic [2:0] fo = 3'($urandom) & 3'($urandom) & 3'($urandom);
        apply(rv ? "R5 random" : "R6 random", 1, rv, mk, ls, fo,
              ($urandom % 4) != 0, 0);
      end
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule